// File: doc/BRIEF.md
# Electronic Shutter Line Sequencer

This block paces the electronic shutter of an interline image sensor. It counts horizontal lines inside each field and, from a 9-bit shutter code captured at the start of the field, decides which lines receive a substrate discharge pulse. Each discharged line empties the photodiodes, so only the lines after the last discharge add to the exposure. A larger code discharges more lines and gives a shorter exposure. With the shutter off, the sensor integrates for the whole field.

The block also produces the sensor readout pulse. This pulse is active low and lasts a set number of clocks on one fixed line near the start of the field. A readout-inhibit control can hold it inactive. The shutter code, the 525/625-line standard select and the readout inhibit are all sampled together at the field-start strobe. Changes to them during a field have no effect until the next field starts.

Codes above the last valid line of the selected standard turn the shutter off. This includes the one reserved code directly above that line. A shutter-active flag reports whether the code latched for the current field enables the shutter.

Top module: `xsub_line_seq`

## Requirements
- R1: After reset, sub_pulse_en is 0, both readout_n bits are 1, and shutter_active is 0.
- R2: shutter_val, std_625 and rd_inhibit are captured only in a cycle where field_stb is 1. If they change at any other time, pulse counts, readout and shutter_active for the running field do not change.
- R3: The line index resets to 0 on field_stb (field_stb wins over line_stb in the same cycle). Each line_stb adds 1 to it. It stops at the last line of the field: 261 when std_625=0, 311 when std_625=1.
- R4: With std_625=0, codes 0 to 261 enable the shutter (shutter_active=1). Codes of 300 and above, which are valid for the 625-line standard, do not.
- R5: With std_625=1, codes 0 to 311 enable the shutter.
- R6: The reserved code (262 for std_625=0, 312 for std_625=1) and every code above it turn the shutter off. In that case shutter_active is 0 and no substrate pulse is produced in the field.
- R7: With the shutter on, sub_pulse_en is high for one clock, in the cycle after each line start (the field_stb, or a line_stb that advances the index), when the new line index is not greater than the code. This gives code+1 pulses per field.
- R8: A line_stb that arrives when the index has already stopped at the last line produces no substrate pulse, even when the code equals that last line.
- R9: Both readout_n bits go low together for RD_CLKS clocks (default 8). This starts in the cycle after the strobe that makes the line index equal to RD_LINE (default 1). Otherwise both bits are 1.
- R10: When rd_inhibit is 1 at field start, both readout_n bits stay 1 for the whole field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| field_stb | input | 1 | One-clock field-start strobe |
| line_stb | input | 1 | One-clock line-start strobe |
| shutter_val | input | 9 | Shutter code, sampled at field start |
| std_625 | input | 1 | 1 selects the 625-line standard, 0 the 525-line standard |
| rd_inhibit | input | 1 | 1 holds the readout pulse inactive |
| sub_pulse_en | output | 1 | One-clock substrate discharge enable per discharged line |
| readout_n | output | 2 | Readout pulses, active low, identical bits |
| shutter_active | output | 1 | Latched code enables the shutter |

## Verification
On every cycle, the assertions check the following. The captured settings hold between field strobes. The line index never exceeds the last line of the latched standard and returns to zero after a field strobe. A substrate pulse never appears without a strobe in the cycle before it, never appears while the shutter is off, and never follows a strobe on a stopped counter. The two readout bits always agree and stay high while the inhibit is latched. Only the bench's scenarios can show the exact per-field pulse counts for each code and standard. They also show the position and width of the readout pulse, the effect of a field restart in mid-field, and the fact that mid-field changes to the inputs are ignored.

// File: rtl/xls_pkg.sv
package xls_pkg;

  // Last line index of a field for the selected standard.
  function automatic int last_line(input logic std625, input int lim_a, input int lim_b);
    return std625 ? lim_b : lim_a;
  endfunction

  // A code enables the shutter only when it does not exceed the last line.
  // The reserved code (last+1) and everything above it fall outside.
  function automatic bit shutter_on(input int code, input int last);
    return code <= last;
  endfunction

  // A line is discharged when its index is not past the code.
  function automatic bit line_discharged(input int line, input int code);
    return line <= code;
  endfunction

endpackage

// File: rtl/xls_field_latch.sv
module xls_field_latch #(
  parameter int VAL_W = 9,
  parameter int LIM_A = 261,
  parameter int LIM_B = 311
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_stb,
  input  logic [VAL_W-1:0] shutter_val,
  input  logic             std_625,
  input  logic             rd_inhibit,
  output logic [VAL_W-1:0] val_lat,
  output logic             std_lat,
  output logic             inh_lat,
  output logic [VAL_W-1:0] val_nxt,
  output logic             std_nxt,
  output logic             inh_nxt,
  output logic [VAL_W-1:0] lim_nxt,
  output logic [VAL_W-1:0] lim_cur,
  output logic             on_nxt,
  output logic             on_cur
);
  localparam logic [VAL_W-1:0] VAL_OFF = '1;

  always_comb begin
    val_nxt = field_stb ? shutter_val : val_lat;
    std_nxt = field_stb ? std_625     : std_lat;
    inh_nxt = field_stb ? rd_inhibit  : inh_lat;
  end

  always_comb begin
    lim_nxt = VAL_W'(xls_pkg::last_line(std_nxt, LIM_A, LIM_B));
    lim_cur = VAL_W'(xls_pkg::last_line(std_lat, LIM_A, LIM_B));
    on_nxt  = xls_pkg::shutter_on(int'(val_nxt), int'(lim_nxt));
    on_cur  = xls_pkg::shutter_on(int'(val_lat), int'(lim_cur));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_lat <= VAL_OFF;
      std_lat <= 1'b0;
      inh_lat <= 1'b1;
    end else begin
      val_lat <= val_nxt;
      std_lat <= std_nxt;
      inh_lat <= inh_nxt;
    end
  end
endmodule

// File: rtl/xls_line_ctr.sv
module xls_line_ctr #(
  parameter int VAL_W = 9,
  parameter int LIM_A = 261
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_stb,
  input  logic             line_stb,
  input  logic [VAL_W-1:0] lim_nxt,
  output logic [VAL_W-1:0] line_cnt,
  output logic [VAL_W-1:0] line_nxt,
  output logic             line_start
);
  logic can_step;

  always_comb begin
    can_step   = line_stb && (line_cnt < lim_nxt);
    line_start = field_stb || can_step;
    if (field_stb)     line_nxt = '0;
    else if (can_step) line_nxt = line_cnt + 1'b1;
    else               line_nxt = line_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_cnt <= VAL_W'(LIM_A);
    else        line_cnt <= line_nxt;
  end
endmodule

// File: rtl/xls_xsub_gen.sv
module xls_xsub_gen #(
  parameter int VAL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             on_nxt,
  input  logic [VAL_W-1:0] line_nxt,
  input  logic [VAL_W-1:0] val_nxt,
  output logic             sub_pulse_en
);
  logic fire;

  always_comb
    fire = line_start && on_nxt &&
           xls_pkg::line_discharged(int'(line_nxt), int'(val_nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sub_pulse_en <= 1'b0;
    else        sub_pulse_en <= fire;
  end
endmodule

// File: rtl/xls_readout_gen.sv
module xls_readout_gen #(
  parameter int VAL_W   = 9,
  parameter int RD_LINE = 1,
  parameter int RD_CLKS = 8,
  parameter int NRD     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [VAL_W-1:0] line_nxt,
  input  logic             inh_lat,
  output logic [NRD-1:0]   readout_n
);
  localparam int CW = $clog2(RD_CLKS + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(RD_CLKS);

  logic [CW-1:0] rd_cnt;
  logic          rd_go;
  logic          rd_on;

  always_comb rd_go = line_start && (line_nxt == VAL_W'(RD_LINE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rd_cnt <= '0;
    else if (rd_go)        rd_cnt <= CNT_LOAD;
    else if (rd_cnt != '0) rd_cnt <= rd_cnt - 1'b1;
  end

  always_comb rd_on = (rd_cnt != '0) && !inh_lat;

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign readout_n[g] = ~rd_on;
  end
endmodule

// File: rtl/xsub_line_seq.sv
module xsub_line_seq #(
  parameter int VAL_W   = 9,
  parameter int LIM_A   = 261,
  parameter int LIM_B   = 311,
  parameter int RD_LINE = 1,
  parameter int RD_CLKS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_stb,
  input  logic             line_stb,
  input  logic [VAL_W-1:0] shutter_val,
  input  logic             std_625,
  input  logic             rd_inhibit,
  output logic             sub_pulse_en,
  output logic [1:0]       readout_n,
  output logic             shutter_active
);
  logic [VAL_W-1:0] val_lat, val_nxt, lim_nxt, lim_cur;
  logic             std_lat, std_nxt, inh_lat, inh_nxt, on_nxt, on_cur;
  logic [VAL_W-1:0] line_cnt, line_nxt;
  logic             line_start;

  xls_field_latch #(.VAL_W(VAL_W), .LIM_A(LIM_A), .LIM_B(LIM_B)) u_latch (
    .clk(clk), .rst_n(rst_n), .field_stb(field_stb), .shutter_val(shutter_val),
    .std_625(std_625), .rd_inhibit(rd_inhibit),
    .val_lat(val_lat), .std_lat(std_lat), .inh_lat(inh_lat),
    .val_nxt(val_nxt), .std_nxt(std_nxt), .inh_nxt(inh_nxt),
    .lim_nxt(lim_nxt), .lim_cur(lim_cur), .on_nxt(on_nxt), .on_cur(on_cur)
  );

  xls_line_ctr #(.VAL_W(VAL_W), .LIM_A(LIM_A)) u_ctr (
    .clk(clk), .rst_n(rst_n), .field_stb(field_stb), .line_stb(line_stb),
    .lim_nxt(lim_nxt), .line_cnt(line_cnt), .line_nxt(line_nxt),
    .line_start(line_start)
  );

  xls_xsub_gen #(.VAL_W(VAL_W)) u_xsub (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .on_nxt(on_nxt),
    .line_nxt(line_nxt), .val_nxt(val_nxt), .sub_pulse_en(sub_pulse_en)
  );

  xls_readout_gen #(.VAL_W(VAL_W), .RD_LINE(RD_LINE), .RD_CLKS(RD_CLKS), .NRD(2)) u_rd (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_nxt(line_nxt),
    .inh_lat(inh_lat), .readout_n(readout_n)
  );

  assign shutter_active = on_cur;
endmodule

// File: rtl/xsub_line_seq_chk.sv
module xsub_line_seq_chk #(
  parameter int VAL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             field_stb,
  input logic             line_stb,
  input logic             sub_pulse_en,
  input logic [1:0]       readout_n,
  input logic             shutter_active,
  input logic [VAL_W-1:0] line_cnt,
  input logic [VAL_W-1:0] lim_cur,
  input logic [VAL_W-1:0] val_lat,
  input logic             std_lat,
  input logic             inh_lat
);
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !field_stb |=> ($stable(val_lat) && $stable(std_lat) && $stable(inh_lat)));

  p_line_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_cnt <= lim_cur);

  p_line_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    field_stb |=> (line_cnt == '0));

  p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !shutter_active |-> !sub_pulse_en);

  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sub_pulse_en |-> $past(field_stb || line_stb));

  p_no_sat_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && !field_stb && line_cnt == lim_cur) |=> !sub_pulse_en);

  p_rd_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (readout_n == 2'b00) || (readout_n == 2'b11));

  p_rd_inhibit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inh_lat |-> (readout_n == 2'b11));
endmodule

bind xsub_line_seq xsub_line_seq_chk #(.VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .field_stb(field_stb), .line_stb(line_stb),
  .sub_pulse_en(sub_pulse_en), .readout_n(readout_n),
  .shutter_active(shutter_active), .line_cnt(line_cnt), .lim_cur(lim_cur),
  .val_lat(val_lat), .std_lat(std_lat), .inh_lat(inh_lat)
);

// File: tb/sim_xsub_line_seq.sv
`timescale 1ns/1ps
module sim_xsub_line_seq;
  localparam int SP      = 10;
  localparam int RD_CLKS = 8;

  typedef struct packed {
    logic       std;
    logic [8:0] val;
    logic       inh;
    logic [9:0] exp_pulses;
    logic       exp_act;
    logic [4:0] exp_rd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 9'd0,   1'b0, 10'd1,   1'b1, 5'd8},
    '{1'b0, 9'd100, 1'b1, 10'd101, 1'b1, 5'd0},
    '{1'b0, 9'd261, 1'b0, 10'd262, 1'b1, 5'd8},
    '{1'b0, 9'd262, 1'b0, 10'd0,   1'b0, 5'd8},
    '{1'b0, 9'd263, 1'b1, 10'd0,   1'b0, 5'd0},
    '{1'b0, 9'd511, 1'b0, 10'd0,   1'b0, 5'd8},
    '{1'b1, 9'd311, 1'b0, 10'd312, 1'b1, 5'd8},
    '{1'b1, 9'd312, 1'b1, 10'd0,   1'b0, 5'd0},
    '{1'b1, 9'd290, 1'b0, 10'd291, 1'b1, 5'd8},
    '{1'b0, 9'd300, 1'b0, 10'd0,   1'b0, 5'd8},
    '{1'b1, 9'd0,   1'b0, 10'd1,   1'b1, 5'd8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic field_stb = 1'b0, line_stb = 1'b0, std_625 = 1'b0, rd_inhibit = 1'b1;
  logic [8:0] shutter_val = '0;
  logic sub_pulse_en, shutter_active;
  logic [1:0] readout_n;

  int n_chk = 0, n_fail = 0;
  int pulses = 0, rd_low = 0;

  always #2 clk = ~clk;

  xsub_line_seq u0 (
    .clk(clk), .rst_n(rst_n), .field_stb(field_stb), .line_stb(line_stb),
    .shutter_val(shutter_val), .std_625(std_625), .rd_inhibit(rd_inhibit),
    .sub_pulse_en(sub_pulse_en), .readout_n(readout_n), .shutter_active(shutter_active)
  );

  always @(negedge clk) begin
    if (sub_pulse_en === 1'b1) pulses++;
    if (readout_n === 2'b00) rd_low++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic start_field(input logic s, input logic [8:0] v, input logic inh);
    @(negedge clk);
    pulses = 0; rd_low = 0;
    std_625 = s; shutter_val = v; rd_inhibit = inh; field_stb = 1'b1;
    @(negedge clk);
    field_stb = 1'b0;
    idle(SP);
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) begin
      line_stb = 1'b1;
      @(negedge clk);
      line_stb = 1'b0;
      idle(SP - 1);
    end
  endtask

  initial begin
    #(190000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state
    check("R1 sub_pulse_en", int'(sub_pulse_en), 0);
    check("R1 readout_n", int'(readout_n), 3);
    check("R1 shutter_active", int'(shutter_active), 0);
    rst_n = 1'b1;
    idle(3);

    // Table walk: R4 R5 R6 R7 R8 R9 R10
    for (int k = 0; k < NV; k++) begin
      start_field(TBL[k].std, TBL[k].val, TBL[k].inh);
      lines(TBL[k].std ? 316 : 266);
      idle(SP);
      check($sformatf("R7/R6/R8 pulses vec%0d", k), pulses, int'(TBL[k].exp_pulses));
      check($sformatf("R4/R5/R6 active vec%0d", k), int'(shutter_active), int'(TBL[k].exp_act));
      check($sformatf("R9/R10 readout clocks vec%0d", k), rd_low, int'(TBL[k].exp_rd));
    end

    // R9 readout position and width
    start_field(1'b0, 9'd50, 1'b0);
    check("R9 no readout on line 0", int'(readout_n), 3);
    line_stb = 1'b1;
    @(negedge clk);
    line_stb = 1'b0;
    check("R9 readout low after line 1", int'(readout_n), 0);
    idle(RD_CLKS - 1);
    check("R9 readout still low at last clock", int'(readout_n), 0);
    idle(1);
    check("R9 readout released", int'(readout_n), 3);

    // R2 mid-field changes ignored
    start_field(1'b0, 9'd261, 1'b1);
    lines(3);
    shutter_val = 9'd20; std_625 = 1'b1; rd_inhibit = 1'b0;
    lines(313);
    idle(SP);
    check("R2 pulses unchanged by mid-field inputs", pulses, 262);
    check("R2 inhibit held mid-field", rd_low, 0);
    check("R2 active unchanged", int'(shutter_active), 1);

    // R2 value change mid-field, off code latched
    start_field(1'b0, 9'd400, 1'b0);
    shutter_val = 9'd5;
    lines(20);
    idle(SP);
    check("R2 off code stays off in field", pulses, 0);

    // R3 field restart mid-field
    start_field(1'b0, 9'd5, 1'b1);
    lines(10);
    @(negedge clk);
    field_stb = 1'b1;
    @(negedge clk);
    field_stb = 1'b0;
    idle(SP);
    lines(10);
    idle(SP);
    check("R3 restart recounts lines", pulses, 12);

    // R3 field strobe wins over line strobe
    start_field(1'b0, 9'd0, 1'b1);
    lines(4);
    @(negedge clk);
    pulses = 0;
    field_stb = 1'b1; line_stb = 1'b1;
    @(negedge clk);
    field_stb = 1'b0; line_stb = 1'b0;
    idle(SP);
    lines(3);
    idle(SP);
    check("R3 simultaneous strobes restart at line 0", pulses, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule